// File: doc/BRIEF.md
# Programmable 3x3 Colour Matrix for a Pixel Stream

This block sits in a display pipe and multiplies every RGB pixel by a programmable 3x3 matrix. Each output channel is the dot product of one matrix row with the input R, G and B values. A signed pre-offset is added to each input channel before the multiply, and a signed post-offset is added to each output channel after it. Every intermediate result that feeds a 10-bit channel is clamped to 0..1023. After reset the matrix is the identity and all offsets are zero, so pixels pass through unchanged.

Each coefficient is a 16-bit word in a compact floating form: a sign, a 3-bit range code and a 9-bit mantissa. The range code slides the mantissa's weight so that the nine mantissa bits always cover the active range. The datapath turns each word into a signed fixed-point multiplier with 12 fractional bits. Software writes the settings over a simple word-wide register port. The writes collect in a pending copy, and that copy is transferred to the working copy only on a frame-start strobe. A frame is therefore always processed with one consistent matrix.

Pixels enter and leave as valid-qualified 30-bit words. The block accepts one pixel every cycle, and each result appears a fixed number of cycles after its input.

Top module: `cmx_color_matrix`

## Requirements
- R1: After reset the block behaves as the identity. The matrix diagonal is 0x7800 and every other coefficient is zero. All offsets are zero. `out_valid` and `out_pix` are zero. While the reset settings are in force, every pixel leaves equal to the pixel that entered.
- R2: The coefficient word is laid out as follows. Bit 15 is the sign, bits 14:12 are the range code and bits 11:3 are the mantissa m. Bits 2:0 are ignored. The magnitude is m·2^-k, where k is 9, 10, 11 or 12 for codes 0, 1, 2 and 3, and k is 8 for code 7 and 7 for code 6. Codes 4 and 5 give a coefficient of zero.
- R3: The register layout is fixed. Word 2r holds row r, column 0 in bits 31:16 and row r, column 1 in bits 15:0. Word 2r+1 holds row r, column 2 in bits 31:16, and its lower half is ignored. Rows 0, 1 and 2 produce the output R, G and B channels. Columns 0, 1 and 2 multiply the input R, G and B channels. Pixels are packed with R in bits 29:20, G in bits 19:10 and B in bits 9:0.
- R4: Words 6, 7 and 8 hold the pre-offsets for input channels R, G and B, as 11-bit two's complement values in bits 10:0. Each pre-offset is added to its input channel, and the sum is clamped to 0..1023.
- R5: Each output channel is the sum of three products of a coefficient and a clamped input. The sum is kept at full width and then rounded to an integer at 12 fractional bits. Rounding is to the nearest value, and a tie rounds up, i.e. floor((s+2048)/4096).
- R6: Words 9, 10 and 11 hold the post-offsets for output channels R, G and B, in the same 11-bit form as the pre-offsets. Each post-offset is added to its rounded sum, and the result is clamped. A negative result becomes 0, and a result above 1023 becomes 1023.
- R7: A register write changes only the pending settings. The settings in use take the pending values only in the cycle after `frame_start` is high. A write that coincides with the strobe does not reach the settings in use until the next strobe.
- R8: `out_valid` follows `in_valid` exactly 3 clock cycles later. `out_pix` keeps its value in every cycle in which `out_valid` is low.
- R9: Pixels may arrive on consecutive cycles. Each pixel of a back-to-back burst produces its own correct result, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start strobe that applies the pending settings |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 30 | Input pixel {R,G,B}, 10 bits each |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 30 | Output pixel {R,G,B}, 10 bits each |

## Verification
An input pixel is captured at the first rising edge after it is driven. It passes through the input clamp register, the dot-product register and the output register, so its result is visible from the third rising edge onward. The bench records, for every pixel it drives, the expected value and the edge count at which that result is due. At every falling edge it compares `out_pix` against the oldest record and checks that the current edge count matches the recorded one. In cycles without a valid output it checks that the output has held. Setting changes are applied only between bursts, after the pipe has drained. A write is checked both before and after its strobe.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int CW       = 16;          // coefficient word width
  localparam int FRAC     = 12;          // fractional bits of a decoded coefficient
  localparam int MAG_W    = CW - 1;
  localparam int NCH      = 3;
  localparam int NCOEF    = NCH * NCH;
  localparam int ADDR_W   = 4;
  localparam int PRE_BASE = 6;
  localparam int POST_BASE = 9;
  localparam logic [CW-1:0] UNITY = 16'h7800;

  typedef struct packed {
    logic       ok;
    logic [2:0] sh;
  } range_sel_t;

  // Left shift of the mantissa into 12-fraction units, per range code.
  function automatic range_sel_t range_shift(input logic [2:0] code);
    range_sel_t r;
    r.ok = 1'b1;
    case (code)
      3'd3:    r.sh = 3'd0;
      3'd2:    r.sh = 3'd1;
      3'd1:    r.sh = 3'd2;
      3'd0:    r.sh = 3'd3;
      3'd7:    r.sh = 3'd4;
      3'd6:    r.sh = 3'd5;
      default: begin r.ok = 1'b0; r.sh = 3'd0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cmx_cfg_regs.sv
module cmx_cfg_regs import cmx_pkg::*; #(
  parameter int DW = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  input  logic                          frame_start,
  output logic [NCOEF-1:0][CW-1:0]      act_coef,
  output logic [NCH-1:0][DW:0]          act_pre,
  output logic [NCH-1:0][DW:0]          act_post
);
  logic [NCOEF-1:0][CW-1:0] pend_coef;
  logic [NCH-1:0][DW:0]     pend_pre;
  logic [NCH-1:0][DW:0]     pend_post;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCOEF; k++) begin
        pend_coef[k] <= (k % (NCH + 1) == 0) ? UNITY : '0;
        act_coef[k]  <= (k % (NCH + 1) == 0) ? UNITY : '0;
      end
      pend_pre  <= '0;
      pend_post <= '0;
      act_pre   <= '0;
      act_post  <= '0;
    end else begin
      if (frame_start) begin
        act_coef <= pend_coef;
        act_pre  <= pend_pre;
        act_post <= pend_post;
      end
      if (cfg_we) begin
        for (int r = 0; r < NCH; r++) begin
          if (cfg_addr == ADDR_W'(2 * r)) begin
            pend_coef[NCH*r]     <= cfg_wdata[31:16];
            pend_coef[NCH*r + 1] <= cfg_wdata[15:0];
          end
          if (cfg_addr == ADDR_W'(2 * r + 1))
            pend_coef[NCH*r + 2] <= cfg_wdata[31:16];
        end
        for (int c = 0; c < NCH; c++) begin
          if (cfg_addr == ADDR_W'(PRE_BASE + c))  pend_pre[c]  <= cfg_wdata[DW:0];
          if (cfg_addr == ADDR_W'(POST_BASE + c)) pend_post[c] <= cfg_wdata[DW:0];
        end
      end
    end
  end
endmodule

// File: rtl/cmx_coef_decode.sv
module cmx_coef_decode import cmx_pkg::*; (
  input  logic [CW-1:3]  code_bits,   // sign, range code, mantissa
  output logic [CW-1:0]  coef_val     // signed, FRAC fractional bits
);
  range_sel_t        sel;
  logic [MAG_W-1:0]  mag;

  always_comb begin
    sel = range_shift(code_bits[14:12]);
    mag = sel.ok ? (MAG_W'(code_bits[11:3]) << sel.sh) : '0;
    coef_val = code_bits[15] ? -{1'b0, mag} : {1'b0, mag};
  end
endmodule

// File: rtl/cmx_datapath.sv
module cmx_datapath import cmx_pkg::*; #(
  parameter int DW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NCH*DW-1:0]         in_pix,
  input  logic [NCOEF-1:0][CW-1:0]  coef,
  input  logic [NCH-1:0][DW:0]      pre_off,
  input  logic [NCH-1:0][DW:0]      post_off,
  output logic                      out_valid,
  output logic [NCH*DW-1:0]         out_pix
);
  localparam int XW   = DW + 1;
  localparam int SW   = CW + XW + 2;
  localparam int MAXV = (1 << DW) - 1;
  localparam int HALF = 1 << (FRAC - 1);

  logic signed [DW+1:0] psum  [NCH];
  logic [DW-1:0]        x_d   [NCH];
  logic [DW-1:0]        x_q   [NCH];
  logic signed [SW-1:0] acc_d [NCH];
  logic signed [SW-1:0] acc_q [NCH];
  logic signed [SW-1:0] rnd   [NCH];
  logic signed [SW:0]   osum  [NCH];
  logic [DW-1:0]        y_d   [NCH];
  logic                 v1, v2;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      // channel c of the packed pixel; channel 0 (R) is the top field
      psum[c] = $signed({2'b00, in_pix[(NCH-1-c)*DW +: DW]})
              + $signed({pre_off[c][DW], pre_off[c]});
      if (psum[c] < 0)                        x_d[c] = '0;
      else if (psum[c] > (DW+2)'(MAXV))       x_d[c] = DW'(MAXV);
      else                                    x_d[c] = psum[c][DW-1:0];
    end
    for (int r = 0; r < NCH; r++) begin
      acc_d[r] = '0;
      for (int i = 0; i < NCH; i++)
        acc_d[r] = acc_d[r] + $signed(coef[NCH*r + i]) * $signed({1'b0, x_q[i]});
    end
    for (int r = 0; r < NCH; r++) begin
      rnd[r]  = (acc_q[r] + SW'(HALF)) >>> FRAC;
      osum[r] = $signed({rnd[r][SW-1], rnd[r]})
              + $signed({{(SW-DW){post_off[r][DW]}}, post_off[r]});
      if (osum[r] < 0)                        y_d[r] = '0;
      else if (osum[r] > (SW+1)'(MAXV))       y_d[r] = DW'(MAXV);
      else                                    y_d[r] = osum[r][DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
      out_pix <= '0;
      for (int c = 0; c < NCH; c++) begin
        x_q[c]   <= '0;
        acc_q[c] <= '0;
      end
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      if (in_valid) for (int c = 0; c < NCH; c++) x_q[c] <= x_d[c];
      if (v1)       for (int c = 0; c < NCH; c++) acc_q[c] <= acc_d[c];
      if (v2)       for (int c = 0; c < NCH; c++) out_pix[(NCH-1-c)*DW +: DW] <= y_d[c];
    end
  end
endmodule

// File: rtl/cmx_color_matrix.sv
module cmx_color_matrix import cmx_pkg::*; #(
  parameter int DW = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic                frame_start,
  input  logic                in_valid,
  input  logic [NCH*DW-1:0]   in_pix,
  output logic                out_valid,
  output logic [NCH*DW-1:0]   out_pix
);
  logic [NCOEF-1:0][CW-1:0] act_coef;
  logic [NCOEF-1:0][CW-1:0] dec_coef;
  logic [NCH-1:0][DW:0]     act_pre;
  logic [NCH-1:0][DW:0]     act_post;

  cmx_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .act_coef(act_coef), .act_pre(act_pre), .act_post(act_post)
  );

  for (genvar k = 0; k < NCOEF; k++) begin : g_dec
    cmx_coef_decode u_dec (
      .code_bits(act_coef[k][CW-1:3]),
      .coef_val (dec_coef[k])
    );
  end

  cmx_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .coef(dec_coef), .pre_off(act_pre), .post_off(act_post),
    .out_valid(out_valid), .out_pix(out_pix)
  );
endmodule

// File: rtl/cmx_color_matrix_chk.sv
module cmx_color_matrix_chk import cmx_pkg::*; #(
  parameter int DW = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      frame_start,
  input logic                      out_valid,
  input logic [NCH*DW-1:0]         out_pix,
  input logic [NCOEF-1:0][CW-1:0]  act_coef,
  input logic [NCOEF-1:0][CW-1:0]  dec_coef
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd0) |-> !out_valid);

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_pix));

  // R7
  apply_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(frame_start)) |-> $stable(act_coef));

  for (genvar k = 0; k < NCOEF; k++) begin : g_k
    // R2
    unused_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (act_coef[k][14:13] == 2'b10) |-> (dec_coef[k] == '0));
    // R2
    sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (dec_coef[k] != '0) |-> (dec_coef[k][CW-1] == act_coef[k][CW-1]));
  end
endmodule

bind cmx_color_matrix cmx_color_matrix_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
  .out_valid(out_valid), .out_pix(out_pix),
  .act_coef(act_coef), .dec_coef(dec_coef)
);

// File: tb/cmx_color_matrix_tb_top.sv
module cmx_color_matrix_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [29:0] in_pix = '0;
  logic        out_valid;
  logic [29:0] out_pix;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  bit run = 0, done = 0;
  int mdl_c[9], pend_c[9], mdl_pre[3], pend_pre[3], mdl_post[3], pend_post[3];
  logic [29:0] exp_q[$];
  longint      due_q[$];
  string       tag_q[$];
  logic [29:0] last_out = '0;

  cmx_color_matrix dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: value in units of 2^-12
  function automatic int dec(int c);
    int m = (c >> 3) & 511;
    int k;
    case ((c >> 12) & 7)
      0: k = 9;  1: k = 10; 2: k = 11; 3: k = 12;
      7: k = 8;  6: k = 7;  default: k = 0;
    endcase
    if (k == 0) return 0;
    dec = m * (1 << (12 - k));
    if ((c & 32'h8000) != 0) dec = -dec;
  endfunction

  function automatic int sat(longint v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return int'(v);
  endfunction

  function automatic logic [29:0] model(int r, int g, int b);
    int x[3];
    int y[3];
    longint s;
    x[0] = sat(r + mdl_pre[0]); x[1] = sat(g + mdl_pre[1]); x[2] = sat(b + mdl_pre[2]);
    for (int row = 0; row < 3; row++) begin
      s = 0;
      for (int i = 0; i < 3; i++) s += longint'(dec(mdl_c[row*3+i])) * x[i];
      y[row] = sat(((s + 2048) >>> 12) + mdl_post[row]);
    end
    return {10'(y[0]), 10'(y[1]), 10'(y[2])};
  endfunction

  task automatic upd_pend(int a, logic [31:0] d);
    if (a < 6) begin
      if (a % 2 == 0) begin pend_c[(a/2)*3] = int'(d[31:16]); pend_c[(a/2)*3+1] = int'(d[15:0]); end
      else pend_c[(a/2)*3+2] = int'(d[31:16]);
    end else if (a < 9) pend_pre[a-6] = int'($signed(d[10:0]));
    else if (a < 12) pend_post[a-9] = int'($signed(d[10:0]));
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    upd_pend(a, d);
  endtask

  task automatic strobe();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    mdl_c = pend_c; mdl_pre = pend_pre; mdl_post = pend_post;
  endtask

  // R7: write and strobe in the same cycle
  task automatic wr_strobe(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d; frame_start = 1;
    @(negedge clk);
    cfg_we = 0; frame_start = 0;
    mdl_c = pend_c; mdl_pre = pend_pre; mdl_post = pend_post;
    upd_pend(a, d);
  endtask

  task automatic push(int r, int g, int b, string tag);
    @(negedge clk);
    in_valid = 1;
    in_pix = {10'(r), 10'(g), 10'(b)};
    exp_q.push_back(model(r, g, b));
    due_q.push_back(cyc + 3);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sweep(string tag, int n);
    push(0, 0, 0, tag);
    push(1023, 1023, 1023, tag);
    for (int i = 0; i < n; i++)
      push((i * 37 + 5) % 1024, (i * 211) % 1024, 1023 - (i * 53) % 1024, tag);
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // R8 / R9: compare each result at the edge it is due, and hold when idle
  always @(negedge clk) begin
    if (run) begin
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected out_valid", 1, 0);
        else begin
          logic [29:0] e;
          longint due;
          string t;
          e = exp_q.pop_front(); due = due_q.pop_front(); t = tag_q.pop_front();
          chk(out_pix == e, t, out_pix, e);
          chk(cyc == due, "R8 latency", cyc, due);
        end
        last_out = out_pix;
      end else begin
        chk(out_pix == last_out, "R8 hold while idle", out_pix, last_out);
      end
    end
  end

  initial begin
    #(4 * 200000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 9; k++) pend_c[k] = (k % 4 == 0) ? 32'h7800 : 0;
    for (int c = 0; c < 3; c++) begin pend_pre[c] = 0; pend_post[c] = 0; end
    mdl_c = pend_c; mdl_pre = pend_pre; mdl_post = pend_post;
    repeat (5) @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(out_pix == 0, "R1 reset out_pix", out_pix, 0);
    rst = 0;
    run = 1;

    // R1: identity after reset, R9 back-to-back burst
    for (int i = 0; i < 32; i++) push(i * 33, 1023 - i * 33, (i * 97) % 1024, "R1 identity");
    drain();

    // R3 layout with a lower half that must be ignored; R7 not applied before strobe
    wr(0, {16'h0800, 16'h1800});
    wr(1, {16'h2800, 16'hFFFF});
    wr(2, {16'h3FF8, 16'hF800});
    wr(3, {16'h7800, 16'h1234});
    wr(4, {16'h0000, 16'h0000});
    wr(5, {16'h6FF8, 16'h0000});
    sweep("R7 pending not yet applied", 12);
    strobe();
    sweep("R3 layout and R6 clamp", 40);

    // R2: unused codes 4/5 give zero, low bits ignored
    wr(0, {16'h4FF8, 16'h5FFF});
    wr(1, {16'h0807, 16'h0000});
    wr(2, {16'h7807, 16'h3FFF});
    wr(3, {16'hE800, 16'h0000});
    wr(4, {16'h1FF8, 16'h2FF8});
    wr(5, {16'h6007, 16'h0000});
    strobe();
    sweep("R2 range codes", 40);

    // R5: rounding at half, diagonal 0.5
    wr(0, {16'h0800, 16'h0000}); wr(1, 32'h0);
    wr(2, {16'h0000, 16'h0800}); wr(3, 32'h0);
    wr(4, 32'h0);                wr(5, {16'h0800, 16'h0000});
    strobe();
    for (int v = 0; v < 8; v++) push(v, v + 1, 1023 - v, "R5 round to nearest");
    drain();

    // R4: pre-offsets -100, +1000, +3
    wr(6, 32'(-100)); wr(7, 32'd1000); wr(8, 32'd3);
    wr(1, {16'h7800, 16'h0000});
    strobe();
    sweep("R4 pre-offset saturation", 30);

    // R6: limited-range diagonal gain 219/255, post-offset +64, then -200
    wr(6, 0); wr(7, 0); wr(8, 0);
    wr(0, {16'h0DC0, 16'h0000}); wr(1, 32'h0);
    wr(2, {16'h0000, 16'h0DC0}); wr(3, 32'h0);
    wr(4, 32'h0);                wr(5, {16'h0DC0, 16'h0000});
    wr(9, 64); wr(10, 64); wr(11, 32'(-200));
    strobe();
    sweep("R6 limited range and post-offset", 40);

    // R7: write coinciding with the strobe waits for the next strobe
    wr(0, {16'h7800, 16'h0000});
    wr_strobe(2, {16'h0000, 16'hF800});
    sweep("R7 write with strobe", 12);
    strobe();
    sweep("R7 applied at next strobe", 12);

    chk(exp_q.size() == 0, "R9 every pixel produced", exp_q.size(), 0);
    finish_run();
  end
endmodule